// File: doc/BRIEF.md
# Exposure Setting Capture Interface

This block takes the electronic-shutter setting of a sensor timing generator from one of two sources and hands the exposure logic a resolved 2-bit mode and a 9-bit load value. Three shared lines carry the setting. In serial entry they act as a strobe, a bit clock and a data line. In parallel entry the same three lines form a 3-bit speed code, and two mode pins supply the mode. A select pin chooses between the two.

In serial entry a 12-bit frame is clocked in on the rising edges of the bit clock. The load value comes first, least significant bit first. Two embedded mode bits and one unused bit follow. The whole setting moves into a working register when the strobe falls. The mode bits carried in the frame take the place of the mode pins. In parallel entry the code and mode pins are decoded through fixed tables into the load value the exposure counter expects, and the value depends on the video standard input. Every input line passes through a two-flop synchronizer, and the serial clock and strobe are edge-detected on the system clock.

Top module: `shutter_cfg_if`

## Requirements
- R1: After reset with serial entry selected, mode_o is 2'b11 (shutter off) and load_o is 9'h1FF.
- R2: With sel_par_i low, the outputs come from the serial working register. With sel_par_i high, they come from the parallel decode. A change on the pins shows at the outputs within four clock cycles.
- R3: In serial entry, line_dat_i is sampled at each rising edge of line_clk_i. Bits 0 to 8 of the frame form load_o[0] to load_o[8], bit 9 becomes mode_o[1], bit 10 becomes mode_o[0], and bit 11 is discarded.
- R4: The shifted bits reach the outputs only at a falling edge of line_stb_i. While bits are being shifted, the outputs keep the previous setting.
- R5: In serial entry, mode_hi_i and mode_lo_i have no effect on the outputs.
- R6: A strobe after fewer than 12 bits replaces only the positions that were received and keeps the rest. The next frame starts again at bit 0. Bits after the twelfth are ignored.
- R7: In parallel entry, mode_o = {mode_hi_i, mode_lo_i}. The encoding is 00 flickerless, 01 high-speed, 10 low-speed and 11 off.
- R8: In parallel high-speed mode, the code {line_stb_i, line_clk_i, line_dat_i} selects a load value. The values are given as NTSC/PAL pairs: 111 gives 1FF/1FF, 011 gives 176/143, 101 gives 137/105, 001 gives 118/0E6, 110 gives 108/0D6, 010 gives 100/0CE, 100 gives 0FC/0CA, and 000 gives 0FA/0C8.
- R9: In parallel low-speed mode, the same code order (111 first, 000 last) selects 2, 4, ... 16 fields. The load value is 9'h1FF minus half the field count.
- R10: In parallel entry, flickerless mode gives a load of 9'h196 (NTSC) or 9'h149 (PAL, std_pal_i high), and the off mode gives 9'h1FF.
- R11: Line activity during parallel entry leaves the serial working register and the bit count unchanged. On return to serial entry, the last strobed setting appears again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_par_i | input | 1 | 0 selects serial entry, 1 selects parallel entry |
| line_stb_i | input | 1 | Serial strobe, or code bit in parallel entry |
| line_clk_i | input | 1 | Serial bit clock, or code bit in parallel entry |
| line_dat_i | input | 1 | Serial data, or code bit in parallel entry |
| mode_hi_i | input | 1 | First mode pin (parallel entry only) |
| mode_lo_i | input | 1 | Second mode pin (parallel entry only) |
| std_pal_i | input | 1 | 0 selects NTSC tables, 1 selects PAL tables |
| mode_o | output | 2 | Resolved shutter mode |
| load_o | output | 9 | Load value for the exposure counter |

## Verification
A wrong bit count or a misplaced shift shows up as a wrong load or mode value at the next strobe. That is about four cycles after the strobe falls, and the bench compares it against a model built from the frame order. A transfer that happens too early shows as outputs that change in the middle of a frame. Serial state that parallel activity has disturbed shows only when the select returns to serial, so the bench toggles the lines in parallel entry and then checks the restored setting. A decode table error shows within four cycles of the code change, and every code is visited for both standards.

// File: rtl/shut_pkg.sv
package shut_pkg;
  localparam int SHUT_LOAD_W = 9;

  typedef enum logic [1:0] {
    SM_FLICKERLESS = 2'b00,
    SM_HIGH        = 2'b01,
    SM_LOW         = 2'b10,
    SM_OFF         = 2'b11
  } shut_mode_e;

  localparam logic [SHUT_LOAD_W-1:0] LOAD_MAX = 9'h1FF;

  // speed rank 0..7 from the three code lines, rank 0 is code 111
  function automatic logic [2:0] speed_rank(input logic [2:0] code_scd);
    return {~code_scd[0], ~code_scd[1], ~code_scd[2]};
  endfunction

  function automatic logic [SHUT_LOAD_W-1:0] high_load(input logic [2:0] rank,
                                                      input logic pal);
    logic [SHUT_LOAD_W-1:0] v;
    case (rank)
      3'd0:    v = LOAD_MAX;
      3'd1:    v = pal ? 9'h143 : 9'h176;
      3'd2:    v = pal ? 9'h105 : 9'h137;
      3'd3:    v = pal ? 9'h0E6 : 9'h118;
      3'd4:    v = pal ? 9'h0D6 : 9'h108;
      3'd5:    v = pal ? 9'h0CE : 9'h100;
      3'd6:    v = pal ? 9'h0CA : 9'h0FC;
      default: v = pal ? 9'h0C8 : 9'h0FA;
    endcase
    return v;
  endfunction

  // exposure in fields = 2 * (LOAD_MAX - load), rank k gives 2*(k+1) fields
  function automatic logic [SHUT_LOAD_W-1:0] low_load(input logic [2:0] rank);
    return LOAD_MAX - SHUT_LOAD_W'(rank) - 1'b1;
  endfunction

  function automatic logic [SHUT_LOAD_W-1:0] flicker_load(input logic pal);
    return pal ? 9'h149 : 9'h196;
  endfunction
endpackage

// File: rtl/shutter_line_sync.sv
module shutter_line_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/shutter_ser_capture.sv
module shutter_ser_capture #(
  parameter int                   FRAME_BITS = 12,
  parameter int                   KEEP_BITS  = 11,
  parameter int                   CNT_W      = 4,
  parameter logic [KEEP_BITS-1:0] RST_WORD   = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 bit_tick,
  input  logic                 xfer,
  input  logic                 din,
  output logic [KEEP_BITS-1:0] word_q,
  output logic [CNT_W-1:0]     cnt_q
);
  logic [KEEP_BITS-1:0] shift_q;
  logic                 room;
  logic                 keep;

  assign room = cnt_q < CNT_W'(FRAME_BITS);
  assign keep = cnt_q < CNT_W'(KEEP_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= RST_WORD;
      word_q  <= RST_WORD;
      cnt_q   <= '0;
    end else if (en) begin
      if (xfer) begin
        word_q <= shift_q;
        cnt_q  <= '0;
      end else if (bit_tick && room) begin
        if (keep) shift_q[cnt_q] <= din;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/shutter_par_decode.sv
module shutter_par_decode
  import shut_pkg::*;
(
  input  logic [1:0]             mode_pins,
  input  logic [2:0]             code_scd,
  input  logic                   pal,
  output logic [1:0]             mode,
  output logic [SHUT_LOAD_W-1:0] load
);
  logic [2:0] rank;

  assign rank = speed_rank(code_scd);
  assign mode = mode_pins;

  always_comb begin
    case (shut_mode_e'(mode_pins))
      SM_FLICKERLESS: load = flicker_load(pal);
      SM_HIGH:        load = high_load(rank, pal);
      SM_LOW:         load = low_load(rank);
      default:        load = LOAD_MAX;
    endcase
  end
endmodule

// File: rtl/shutter_cfg_if.sv
module shutter_cfg_if
  import shut_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sel_par_i,
  input  logic                   line_stb_i,
  input  logic                   line_clk_i,
  input  logic                   line_dat_i,
  input  logic                   mode_hi_i,
  input  logic                   mode_lo_i,
  input  logic                   std_pal_i,
  output logic [1:0]             mode_o,
  output logic [SHUT_LOAD_W-1:0] load_o
);
  localparam int FRAME_BITS = SHUT_LOAD_W + 3;
  localparam int KEEP_BITS  = SHUT_LOAD_W + 2;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int M_HI_POS   = SHUT_LOAD_W;
  localparam int M_LO_POS   = SHUT_LOAD_W + 1;

  // synced bundle: pal, mode_hi, mode_lo, sel, stb, sclk, dat
  logic [6:0] raw_lines;
  logic [6:0] sync_lines;
  logic       pal_s, mhi_s, mlo_s, sel_s, stb_s, sclk_s, dat_s;
  logic       stb_prev_q, sclk_prev_q;

  assign raw_lines = {std_pal_i, mode_hi_i, mode_lo_i, sel_par_i,
                      line_stb_i, line_clk_i, line_dat_i};

  shutter_line_sync #(
    .W(7), .STAGES(SYNC_STAGES), .RST_VAL(7'b0000100)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_lines), .q(sync_lines)
  );

  assign {pal_s, mhi_s, mlo_s, sel_s, stb_s, sclk_s, dat_s} = sync_lines;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_prev_q  <= 1'b1;
      sclk_prev_q <= 1'b0;
    end else begin
      stb_prev_q  <= stb_s;
      sclk_prev_q <= sclk_s;
    end
  end

  // named internal events
  logic                 ser_sel;
  logic                 sclk_rise;
  logic                 stb_fall;
  logic [KEEP_BITS-1:0] work_q;
  logic [CNT_W-1:0]     frame_cnt;

  assign ser_sel   = ~sel_s;
  assign sclk_rise = sclk_s & ~sclk_prev_q;
  assign stb_fall  = ~stb_s & stb_prev_q;

  shutter_ser_capture #(
    .FRAME_BITS(FRAME_BITS), .KEEP_BITS(KEEP_BITS), .CNT_W(CNT_W),
    .RST_WORD({KEEP_BITS{1'b1}})
  ) u_ser (
    .clk(clk), .rst_n(rst_n), .en(ser_sel), .bit_tick(sclk_rise),
    .xfer(stb_fall), .din(dat_s), .word_q(work_q), .cnt_q(frame_cnt)
  );

  logic [1:0]             par_mode;
  logic [SHUT_LOAD_W-1:0] par_load;

  shutter_par_decode u_par (
    .mode_pins({mhi_s, mlo_s}), .code_scd({stb_s, sclk_s, dat_s}),
    .pal(pal_s), .mode(par_mode), .load(par_load)
  );

  always_comb begin
    if (ser_sel) begin
      mode_o = {work_q[M_HI_POS], work_q[M_LO_POS]};
      load_o = work_q[SHUT_LOAD_W-1:0];
    end else begin
      mode_o = par_mode;
      load_o = par_load;
    end
  end
endmodule

// File: rtl/shutter_cfg_chk.sv
module shutter_cfg_chk #(
  parameter int FRAME_BITS = 12,
  parameter int KEEP_BITS  = 11,
  parameter int CNT_W      = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ser_sel,
  input logic                 stb_fall,
  input logic [KEEP_BITS-1:0] work_q,
  input logic [CNT_W-1:0]     frame_cnt,
  input logic [1:0]           mode_o,
  input logic [8:0]           load_o
);
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_cnt <= CNT_W'(FRAME_BITS));

  p_cnt_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_sel && stb_fall) |=> frame_cnt == '0);

  p_hold_until_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_sel && stb_fall) |=> $stable(work_q));

  p_par_untouched_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_sel |=> ($stable(work_q) && $stable(frame_cnt)));

  p_serial_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ser_sel |-> (load_o == work_q[8:0] && mode_o == {work_q[9], work_q[10]}));

  p_off_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_sel && mode_o == 2'b11) |-> load_o == 9'h1FF);

  p_low_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_sel && mode_o == 2'b10) |-> (load_o >= 9'h1F7 && load_o <= 9'h1FE));
endmodule

bind shutter_cfg_if shutter_cfg_chk #(
  .FRAME_BITS(FRAME_BITS), .KEEP_BITS(KEEP_BITS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_sel(ser_sel), .stb_fall(stb_fall),
  .work_q(work_q), .frame_cnt(frame_cnt), .mode_o(mode_o), .load_o(load_o)
);

// File: tb/shutter_cfg_if_tb.sv
module shutter_cfg_if_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, stb = 1'b1, sclk = 1'b0, dat = 1'b0;
  logic m1 = 1'b0, m2 = 1'b0, pal = 1'b0;
  logic [1:0] mode_o;
  logic [8:0] load_o;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  shutter_cfg_if u_dut (
    .clk(clk), .rst_n(rst_n), .sel_par_i(sel), .line_stb_i(stb),
    .line_clk_i(sclk), .line_dat_i(dat), .mode_hi_i(m1), .mode_lo_i(m2),
    .std_pal_i(pal), .mode_o(mode_o), .load_o(load_o)
  );

  typedef struct {
    string      tag;
    logic [1:0] mode;
    logic [8:0] load;
  } exp_t;
  exp_t exp_q[$];

  // bench model of the serial path
  logic [10:0] m_shift = 11'h7FF;
  logic [10:0] m_work  = 11'h7FF;
  int          m_cnt   = 0;

  task automatic expect_out(input string tag, input logic [1:0] md, input logic [8:0] ld);
    exp_t e;
    e.tag = tag; e.mode = md; e.load = ld;
    exp_q.push_back(e);
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
  endtask

  task automatic expect_serial(input string tag);
    settle();
    expect_out(tag, {m_work[9], m_work[10]}, m_work[8:0]);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      total++;
      if (mode_o !== e.mode || load_o !== e.load) begin
        bad++;
        $display("FAIL %s: mode=%b load=%h expected mode=%b load=%h",
                 e.tag, mode_o, load_o, e.mode, e.load);
      end
    end
  end

  task automatic shift_bits(input logic [11:0] frame, input int n);
    for (int i = 0; i < n; i++) begin
      dat = frame[i % 12];
      repeat (3) @(posedge clk);
      sclk = 1'b1;
      repeat (3) @(posedge clk);
      sclk = 1'b0;
      repeat (3) @(posedge clk);
      if (m_cnt < 11) m_shift[m_cnt] = frame[i % 12];
      if (m_cnt < 12) m_cnt++;
    end
  endtask

  task automatic pulse_strobe();
    stb = 1'b0;
    repeat (4) @(posedge clk);
    stb = 1'b1;
    repeat (4) @(posedge clk);
    m_work = m_shift;
    m_cnt  = 0;
  endtask

  function automatic logic [11:0] mk_frame(input logic [8:0] ld, input logic hi, input logic lo);
    return {1'b0, lo, hi, ld};
  endfunction

  // expected tables restated from the requirements, indexed by pin levels
  function automatic logic [8:0] exp_high(input logic [2:0] scd, input logic p);
    case (scd)
      3'b111: return 9'h1FF;
      3'b011: return p ? 9'h143 : 9'h176;
      3'b101: return p ? 9'h105 : 9'h137;
      3'b001: return p ? 9'h0E6 : 9'h118;
      3'b110: return p ? 9'h0D6 : 9'h108;
      3'b010: return p ? 9'h0CE : 9'h100;
      3'b100: return p ? 9'h0CA : 9'h0FC;
      default: return p ? 9'h0C8 : 9'h0FA;
    endcase
  endfunction

  function automatic logic [8:0] exp_low(input logic [2:0] scd);
    int fields;
    case (scd)
      3'b111: fields = 2;
      3'b011: fields = 4;
      3'b101: fields = 6;
      3'b001: fields = 8;
      3'b110: fields = 10;
      3'b010: fields = 12;
      3'b100: fields = 14;
      default: fields = 16;
    endcase
    return 9'(511 - fields / 2);
  endfunction

  initial begin
    int cyc = 0;
    while (!finished && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state in serial entry
    expect_serial("R1 reset value");
    settle();

    // R3 R5: serial frame with contrary mode pins
    m1 = 1'b1; m2 = 1'b0;
    shift_bits(mk_frame(9'h0FA, 1'b0, 1'b1), 12);
    pulse_strobe();
    expect_serial("R3 R5 serial frame high-speed");

    // R4: mid-frame outputs hold
    shift_bits(mk_frame(9'h1FD, 1'b1, 1'b0), 12);
    expect_out("R4 hold before strobe", 2'b01, 9'h0FA);
    pulse_strobe();
    expect_serial("R3 R4 frame after strobe");

    // R5: mode pins toggled in serial entry
    m1 = 1'b0; m2 = 1'b0;
    settle();
    expect_out("R5 pins ignored", 2'b10, 9'h1FD);

    // R6: short frame, then full frame from count zero
    shift_bits(12'h000, 4);
    pulse_strobe();
    expect_serial("R6 short frame partial replace");
    settle();
    expect_out("R6 short frame value", 2'b10, 9'h1F0);
    shift_bits(mk_frame(9'h123, 1'b0, 1'b0), 12);
    pulse_strobe();
    expect_serial("R6 restart after short frame");

    // R6: long frame, extra ones ignored
    shift_bits(mk_frame(9'h0AA, 1'b1, 1'b1), 12);
    shift_bits(12'hFFF, 3);
    pulse_strobe();
    expect_out("R6 long frame extra bits", 2'b11, 9'h0AA);

    // parallel entry
    sel = 1'b1;
    settle();
    for (int p = 0; p < 2; p++) begin
      pal = p[0];
      m1 = 1'b0; m2 = 1'b1;
      for (int c = 0; c < 8; c++) begin
        {stb, sclk, dat} = 3'(c);
        settle();
        expect_out("R2 R7 R8 high-speed code", 2'b01, exp_high(3'(c), p[0]));
      end
    end
    m1 = 1'b1; m2 = 1'b0;
    for (int c = 0; c < 8; c++) begin
      {stb, sclk, dat} = 3'(c);
      settle();
      expect_out("R7 R9 low-speed code", 2'b10, exp_low(3'(c)));
    end
    m1 = 1'b0; m2 = 1'b0;
    pal = 1'b0;
    settle();
    expect_out("R10 flickerless NTSC", 2'b00, 9'h196);
    pal = 1'b1;
    settle();
    expect_out("R10 flickerless PAL", 2'b00, 9'h149);
    m1 = 1'b1; m2 = 1'b1;
    settle();
    expect_out("R10 off load", 2'b11, 9'h1FF);

    // R11: toggle lines as a would-be frame during parallel entry
    stb = 1'b1; sclk = 1'b0;
    shift_bits(12'h555, 5);
    m_shift = m_work; m_cnt = 0;
    stb = 1'b0;
    repeat (4) @(posedge clk);
    stb = 1'b1; sclk = 1'b0;
    settle();
    sel = 1'b0;
    settle();
    expect_out("R11 serial setting restored", 2'b11, 9'h0AA);
    // R11: the bit count was not advanced: a full frame lands aligned
    shift_bits(mk_frame(9'h16C, 1'b0, 1'b1), 12);
    pulse_strobe();
    expect_out("R11 R3 aligned frame after parallel", 2'b01, 9'h16C);

    repeat (4) @(posedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule